// File: doc/BRIEF.md
# Sponge Padding and Absorb Unit

This block is the input side of a Keccak-style sponge. It takes a message one byte at a time over a valid/ready interface, with a marker on the final byte, and XORs each byte straight into the rate part of a 1600-bit state held inside the block. Byte k of a block lands on state bits 8k+7 down to 8k, so the least significant bit of each byte goes first into the lowest bit of its lane. When a block is full, the block raises a one-cycle request to an external permutation engine. It then waits for that engine's done strobe and loads the permuted state it returns.

A 3-bit mode code, taken with the first byte of each message, picks the rate and the domain-separation byte. The hash modes and the two extendable-output modes use the standard rates. After the last message byte, the block runs one padding cycle. That cycle puts the domain byte directly after the message and the closing 0x80 bit in the last byte of the rate. When the two coincide they merge into a single byte. A message that fills its final block exactly gets one extra block that holds only padding. The capacity bytes never take input. Once the final permutation has returned, the block pulses a completion flag, and the state can then be handed to a squeeze stage.

Top module: `sponge_absorb`

## Requirements
- R1: The mode code (taken on the first byte of a message) sets the rate in bytes: 0→144, 1→136, 2→104, 3→72, 4→168, 5→136, 6→168, 7→136. The byte that fills the rate ends a block, and perm_start_o rises in the next cycle.
- R2: Message byte k of a block is XORed into state_o bits [8k+7:8k] (LSB-first). The state is cleared to zero in the same cycle that the first byte of a new message is taken.
- R3: In the padding cycle, the domain byte is XORed in at the position just after the last message byte: 0x06 for codes 0–3, 0x1F for codes 4–5, 0x07 for codes 6–7. The padding cycle directly follows the accepted last byte, and perm_start_o rises in the cycle after it.
- R4: In the same padding cycle, 0x80 is XORed into the last rate byte (rate minus one). When the message ends one byte short of the rate, that byte receives the domain byte OR 0x80 (0x86 for codes 0–3).
- R5: If the last message byte also fills the block, that block is permuted first, and then one further block made only of padding is absorbed and permuted.
- R6: State bytes at positions equal to or above the rate are never changed by message or padding bytes. They change only when the state is cleared or loaded from perm_state_i.
- R7: in_ready_o is low from the cycle after a block completes until the cycle after perm_done_i. Bytes offered during that time are not taken and do not alter the state.
- R8: perm_start_o is a single-cycle pulse, and at most one request is outstanding. On perm_done_i, state_o takes the value of perm_state_i at the next clock edge.
- R9: absorb_done_o pulses for one cycle, in the cycle after the perm_done_i that answers a message's final block. in_ready_o is high in that cycle, as it is after reset, when state_o is zero.
- R10: Changes of mode_i after the first byte of a message have no effect on the rate or the domain byte of that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Function code, sampled with the first byte of a message |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of the message |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| perm_start_o | output | 1 | One-cycle request to run the permutation on state_o |
| perm_done_i | input | 1 | Permutation finished; perm_state_i is valid |
| perm_state_i | input | 1600 | Permuted state returned by the engine |
| state_o | output | 1600 | Current sponge state |
| absorb_done_o | output | 1 | One-cycle pulse when the whole message is absorbed |

## Verification
An accepted byte appears in state_o right after the capturing edge. perm_start_o is due one cycle after the edge that takes a block-completing byte, or one cycle after the padding cycle, which itself follows the last byte by one cycle. The permuted state and the return of in_ready_o both follow perm_done_i by one edge, and absorb_done_o comes in that same cycle after the final block. A behavioural model in the bench advances on each rising edge from the same inputs, and the outputs are compared with it on every falling edge, half a cycle after they settle. Each message also has its full sequence of expected block states, built from a padded copy of the message, and the bench compares that sequence with the states captured at each perm_start_o.

// File: rtl/sponge_absorb_pkg.sv
package sponge_absorb_pkg;

   localparam int BYTE_W = 8;
   localparam int MODE_W = 3;

   // rate in bits for each function family member
   localparam int RATE_BITS_H224 = 1152;
   localparam int RATE_BITS_H256 = 1088;
   localparam int RATE_BITS_H384 = 832;
   localparam int RATE_BITS_H512 = 576;
   localparam int RATE_BITS_X128 = 1344;
   localparam int RATE_BITS_X256 = 1088;
   localparam int MAX_RATE_BITS  = RATE_BITS_X128;
   localparam int MAX_RATE_BYTES = MAX_RATE_BITS / BYTE_W;

   localparam logic [BYTE_W-1:0] DOM_HASH = 8'h06;
   localparam logic [BYTE_W-1:0] DOM_XOF  = 8'h1F;
   localparam logic [BYTE_W-1:0] DOM_RAW  = 8'h07;
   localparam logic [BYTE_W-1:0] PAD_END  = 8'h80;

   typedef enum logic [MODE_W-1:0] {
      MD_H224  = 3'd0,
      MD_H256  = 3'd1,
      MD_H384  = 3'd2,
      MD_H512  = 3'd3,
      MD_X128  = 3'd4,
      MD_X256  = 3'd5,
      MD_RX128 = 3'd6,
      MD_RX256 = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      PH_TAKE = 2'd0,
      PH_PAD  = 2'd1,
      PH_PERM = 2'd2
   } phase_e;

endpackage

// File: rtl/sponge_absorb_mode_dec.sv
module sponge_absorb_mode_dec
   import sponge_absorb_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic [MODE_W-1:0] mode_i,
   output logic [IDX_W-1:0]  last_idx_o,
   output logic [BYTE_W-1:0] dom_o
);

   int unsigned rbits;

   always_comb begin
      unique case (mode_e'(mode_i))
         MD_H224:  begin rbits = RATE_BITS_H224; dom_o = DOM_HASH; end
         MD_H256:  begin rbits = RATE_BITS_H256; dom_o = DOM_HASH; end
         MD_H384:  begin rbits = RATE_BITS_H384; dom_o = DOM_HASH; end
         MD_H512:  begin rbits = RATE_BITS_H512; dom_o = DOM_HASH; end
         MD_X128:  begin rbits = RATE_BITS_X128; dom_o = DOM_XOF;  end
         MD_X256:  begin rbits = RATE_BITS_X256; dom_o = DOM_XOF;  end
         MD_RX128: begin rbits = RATE_BITS_X128; dom_o = DOM_RAW;  end
         default:  begin rbits = RATE_BITS_X256; dom_o = DOM_RAW;  end
      endcase
      last_idx_o = IDX_W'(rbits / BYTE_W - 1);
   end

endmodule

// File: rtl/sponge_absorb_ctrl.sv
module sponge_absorb_ctrl
   import sponge_absorb_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic              in_last_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [IDX_W-1:0]  last_idx_i,
   input  logic              perm_done_i,
   output logic              in_ready_o,
   output logic [MODE_W-1:0] mode_eff_o,
   output logic              clr_o,
   output logic              wr_en_o,
   output logic              pad_en_o,
   output logic              load_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              perm_start_o,
   output logic              absorb_done_o
);

   phase_e            ph_q;
   logic [IDX_W-1:0]  idx_q;
   logic [MODE_W-1:0] mode_q;
   logic              open_q;
   logic              tail_q;
   logic              fin_q;
   logic              start_q;
   logic              done_q;
   logic              accept;
   logic              at_end;

   assign in_ready_o    = (ph_q == PH_TAKE);
   assign accept        = in_valid_i && in_ready_o;
   assign mode_eff_o    = open_q ? mode_q : mode_i;
   assign clr_o         = accept && !open_q;
   assign wr_en_o       = accept;
   assign pad_en_o      = (ph_q == PH_PAD);
   assign load_o        = (ph_q == PH_PERM) && perm_done_i;
   assign idx_o         = idx_q;
   assign at_end        = (idx_q == last_idx_i);
   assign perm_start_o  = start_q;
   assign absorb_done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_TAKE;
         idx_q   <= '0;
         mode_q  <= '0;
         open_q  <= 1'b0;
         tail_q  <= 1'b0;
         fin_q   <= 1'b0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (ph_q)
            PH_TAKE: begin
               if (accept) begin
                  if (!open_q) begin
                     open_q <= 1'b1;
                     mode_q <= mode_i;
                  end
                  if (at_end) begin
                     idx_q   <= '0;
                     ph_q    <= PH_PERM;
                     start_q <= 1'b1;
                     tail_q  <= in_last_i;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     if (in_last_i) ph_q <= PH_PAD;
                  end
               end
            end
            PH_PAD: begin
               idx_q   <= '0;
               fin_q   <= 1'b1;
               start_q <= 1'b1;
               ph_q    <= PH_PERM;
            end
            PH_PERM: begin
               if (perm_done_i) begin
                  if (tail_q) begin
                     tail_q <= 1'b0;
                     ph_q   <= PH_PAD;
                  end else if (fin_q) begin
                     fin_q  <= 1'b0;
                     open_q <= 1'b0;
                     done_q <= 1'b1;
                     ph_q   <= PH_TAKE;
                  end else begin
                     ph_q <= PH_TAKE;
                  end
               end
            end
            default: ph_q <= PH_TAKE;
         endcase
      end
   end

endmodule

// File: rtl/sponge_absorb_state.sv
module sponge_absorb_state
   import sponge_absorb_pkg::*;
#(
   parameter int STATE_W   = 1600,
   parameter int RATE_BMAX = 168,
   parameter int IDX_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               load_i,
   input  logic [STATE_W-1:0] perm_state_i,
   input  logic               wr_en_i,
   input  logic [BYTE_W-1:0]  wr_byte_i,
   input  logic               pad_en_i,
   input  logic [BYTE_W-1:0]  pad_dom_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [IDX_W-1:0]   last_idx_i,
   output logic [STATE_W-1:0] state_o
);

   localparam int N_BYTES = STATE_W / BYTE_W;

   for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
      logic [BYTE_W-1:0] cur_q;
      logic [BYTE_W-1:0] nxt;

      if (j < RATE_BMAX) begin : g_rate
         // rate byte: message, domain and closing bit can all land here
         logic [BYTE_W-1:0] mask;
         always_comb begin
            mask = '0;
            if (wr_en_i  && idx_i      == IDX_W'(j)) mask = mask | wr_byte_i;
            if (pad_en_i && idx_i      == IDX_W'(j)) mask = mask | pad_dom_i;
            if (pad_en_i && last_idx_i == IDX_W'(j)) mask = mask | PAD_END;
            nxt = (clr_i ? '0 : cur_q) ^ mask;
         end
      end else begin : g_cap
         // capacity byte: no input path at all
         assign nxt = clr_i ? '0 : cur_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cur_q <= '0;
         else if (load_i) cur_q <= perm_state_i[j*BYTE_W +: BYTE_W];
         else             cur_q <= nxt;
      end

      assign state_o[j*BYTE_W +: BYTE_W] = cur_q;
   end

endmodule

// File: rtl/sponge_absorb.sv
module sponge_absorb
   import sponge_absorb_pkg::*;
#(
   parameter  int LANE_W  = 64,
   parameter  int N_LANES = 25,
   localparam int STATE_W = LANE_W * N_LANES,
   localparam int IDX_W   = $clog2(MAX_RATE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MODE_W-1:0]  mode_i,
   input  logic               in_valid_i,
   input  logic [BYTE_W-1:0]  in_byte_i,
   input  logic               in_last_i,
   output logic               in_ready_o,
   output logic               perm_start_o,
   input  logic               perm_done_i,
   input  logic [STATE_W-1:0] perm_state_i,
   output logic [STATE_W-1:0] state_o,
   output logic               absorb_done_o
);

   initial begin : elab_chk
      assert (STATE_W % BYTE_W == 0)
         else $error("state width %0d is not a whole number of bytes", STATE_W);
      assert (STATE_W > MAX_RATE_BITS)
         else $error("state width %0d leaves no capacity", STATE_W);
   end

   logic [MODE_W-1:0] mode_eff;
   logic [IDX_W-1:0]  last_idx;
   logic [BYTE_W-1:0] dom;
   logic              clr;
   logic              wr_en;
   logic              pad_en;
   logic              load;
   logic [IDX_W-1:0]  idx;

   sponge_absorb_mode_dec #(
      .IDX_W (IDX_W)
   ) u_dec (
      .mode_i     (mode_eff),
      .last_idx_o (last_idx),
      .dom_o      (dom)
   );

   sponge_absorb_ctrl #(
      .IDX_W (IDX_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid_i    (in_valid_i),
      .in_last_i     (in_last_i),
      .mode_i        (mode_i),
      .last_idx_i    (last_idx),
      .perm_done_i   (perm_done_i),
      .in_ready_o    (in_ready_o),
      .mode_eff_o    (mode_eff),
      .clr_o         (clr),
      .wr_en_o       (wr_en),
      .pad_en_o      (pad_en),
      .load_o        (load),
      .idx_o         (idx),
      .perm_start_o  (perm_start_o),
      .absorb_done_o (absorb_done_o)
   );

   sponge_absorb_state #(
      .STATE_W   (STATE_W),
      .RATE_BMAX (MAX_RATE_BYTES),
      .IDX_W     (IDX_W)
   ) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr),
      .load_i       (load),
      .perm_state_i (perm_state_i),
      .wr_en_i      (wr_en),
      .wr_byte_i    (in_byte_i),
      .pad_en_i     (pad_en),
      .pad_dom_i    (dom),
      .idx_i        (idx),
      .last_idx_i   (last_idx),
      .state_o      (state_o)
   );

endmodule

// File: rtl/sponge_absorb_chk.sv
module sponge_absorb_chk
   import sponge_absorb_pkg::*;
#(
   parameter int STATE_W = 1600
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_ready_o,
   input logic               perm_start_o,
   input logic               perm_done_i,
   input logic               absorb_done_o,
   input logic [STATE_W-1:0] state_o
);

   logic busy_q;
   logic [STATE_W-MAX_RATE_BITS-1:0] cap;

   assign cap = state_o[STATE_W-1:MAX_RATE_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_q <= 1'b0;
      else if (perm_start_o) busy_q <= 1'b1;
      else if (perm_done_i)  busy_q <= 1'b0;
   end

   assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      perm_start_o |=> !perm_start_o);

   assert_single_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !perm_start_o);

   assert_no_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q || perm_start_o) |-> !in_ready_o);

   assert_done_after_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      absorb_done_o |-> $past(perm_done_i));

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      absorb_done_o |-> in_ready_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      absorb_done_o |=> !absorb_done_o);

   // bytes past the widest rate change only through a load or a clear
   assert_capacity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !perm_done_i |=> ($stable(cap) || cap == '0));

endmodule

bind sponge_absorb sponge_absorb_chk #(
   .STATE_W (STATE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_ready_o    (in_ready_o),
   .perm_start_o  (perm_start_o),
   .perm_done_i   (perm_done_i),
   .absorb_done_o (absorb_done_o),
   .state_o       (state_o)
);

// File: tb/sponge_absorb_bench.sv
`timescale 1ns/1ps
module sponge_absorb_bench;

   localparam int SW       = 1600;
   localparam int PERM_LAT = 5;
   localparam int WATCHDOG = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_i = '0;
   logic          in_valid_i = 1'b0;
   logic [7:0]    in_byte_i = '0;
   logic          in_last_i = 1'b0;
   logic          in_ready_o;
   logic          perm_start_o;
   logic          perm_done_i = 1'b0;
   logic [SW-1:0] perm_state_i = '0;
   logic [SW-1:0] state_o;
   logic          absorb_done_o;

   always #4 clk = ~clk;   // 125 MHz

   sponge_absorb u_sponge_absorb (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_i        (mode_i),
      .in_valid_i    (in_valid_i),
      .in_byte_i     (in_byte_i),
      .in_last_i     (in_last_i),
      .in_ready_o    (in_ready_o),
      .perm_start_o  (perm_start_o),
      .perm_done_i   (perm_done_i),
      .perm_state_i  (perm_state_i),
      .state_o       (state_o),
      .absorb_done_o (absorb_done_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit ended = 0;

   // ---------- requirement-level helpers ----------
   function automatic int rb_of(input int m);
      case (m)
         0: return 144;  1: return 136;  2: return 104;  3: return 72;
         4: return 168;  5: return 136;  6: return 168;  default: return 136;
      endcase
   endfunction

   function automatic logic [7:0] dom_of(input int m);
      if (m <= 3) return 8'h06;
      if (m <= 5) return 8'h1F;
      return 8'h07;
   endfunction

   // stand-in permutation: any fixed bijection serves
   function automatic logic [SW-1:0] perm_f(input logic [SW-1:0] s);
      return {s[SW-8:0], s[SW-1:SW-7]} ^ {25{64'hA5A5_0F0F_3C3C_9696}};
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // ---------- permutation responder ----------
   int            lat_cnt = 0;
   logic [SW-1:0] snap;
   always @(negedge clk) begin
      if (lat_cnt > 0) begin
         lat_cnt--;
         if (lat_cnt == 0) begin
            perm_done_i  = 1'b1;
            perm_state_i = perm_f(snap);
         end
      end else begin
         perm_done_i = 1'b0;
      end
      if (perm_start_o) begin
         snap    = state_o;
         lat_cnt = PERM_LAT;
      end
   end

   // ---------- cycle reference model ----------
   int            ph_m, idx_m, mode_m, rb_m, mm;
   bit            open_m, tail_m, fin_m, start_m, done_m;
   logic [SW-1:0] st_m;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_m = 0; idx_m = 0; mode_m = 0;
         open_m = 0; tail_m = 0; fin_m = 0; start_m = 0; done_m = 0;
         st_m = '0;
      end else begin
         start_m = 0;
         done_m  = 0;
         case (ph_m)
            0: if (in_valid_i) begin
               mm   = open_m ? mode_m : int'(mode_i);
               rb_m = rb_of(mm);
               if (!open_m) begin
                  open_m = 1; mode_m = mm; st_m = '0;
               end
               st_m[8*idx_m +: 8] ^= in_byte_i;
               if (idx_m == rb_m - 1) begin
                  idx_m = 0; ph_m = 2; start_m = 1; tail_m = in_last_i;
               end else begin
                  idx_m++;
                  if (in_last_i) ph_m = 1;
               end
            end
            1: begin
               rb_m = rb_of(mode_m);
               st_m[8*idx_m +: 8]      ^= dom_of(mode_m);
               st_m[8*(rb_m-1) +: 8]   ^= 8'h80;
               idx_m = 0; fin_m = 1; ph_m = 2; start_m = 1;
            end
            default: if (perm_done_i) begin
               st_m = perm_state_i;
               if (tail_m) begin
                  tail_m = 0; ph_m = 1;
               end else if (fin_m) begin
                  fin_m = 0; open_m = 0; done_m = 1; ph_m = 0;
               end else begin
                  ph_m = 0;
               end
            end
         endcase
      end
   end

   // ---------- per-clock comparison, half a cycle after the edge ----------
   bit run_cmp = 0;
   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         n_chk++;
         if (in_ready_o !== (ph_m == 0)) begin
            n_fail++;
            $display("FAIL R7 in_ready_o act=%b exp=%b at cycle %0d", in_ready_o, (ph_m == 0), cyc);
         end
         n_chk++;
         if (perm_start_o !== start_m) begin
            n_fail++;
            $display("FAIL R8 perm_start_o act=%b exp=%b at cycle %0d", perm_start_o, start_m, cyc);
         end
         n_chk++;
         if (absorb_done_o !== done_m) begin
            n_fail++;
            $display("FAIL R9 absorb_done_o act=%b exp=%b at cycle %0d", absorb_done_o, done_m, cyc);
         end
         n_chk++;
         if (state_o !== st_m) begin
            n_fail++;
            $display("FAIL R2 R7 state_o mismatch at cycle %0d act=%h exp=%h", cyc, state_o, st_m);
         end
      end
   end

   // ---------- block capture at each permutation request ----------
   logic [SW-1:0] blocks[$];
   always @(negedge clk) begin
      if (rst_n && perm_start_o) blocks.push_back(state_o);
   end

   // ---------- watchdog ----------
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !ended) begin
         ended = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=%0d cycles exp=below %0d", cyc, WATCHDOG);
         summary();
         $finish;
      end
   end

   // ---------- one message, end-to-end expected block sequence ----------
   task automatic run_msg(input int m, input int len, input int m_alt, input string tag);
      logic [7:0]    msg[];
      logic [7:0]    padb[];
      logic [SW-1:0] exp_q[$];
      logic [SW-1:0] acc;
      int            rb, nblk, total, waitc;
      rb    = rb_of(m);
      nblk  = len / rb + 1;
      total = nblk * rb;
      msg   = new[len];
      padb  = new[total];
      for (int i = 0; i < len; i++) msg[i] = 8'((i * 37 + len * 11 + m * 5 + 3) & 255);
      for (int i = 0; i < total; i++) padb[i] = (i < len) ? msg[i] : 8'h00;
      padb[len]       = padb[len] | dom_of(m);
      padb[total - 1] = padb[total - 1] | 8'h80;
      acc = '0;
      for (int k = 0; k < nblk; k++) begin
         for (int b = 0; b < rb; b++) acc[8*b +: 8] ^= padb[k*rb + b];
         exp_q.push_back(acc);
         acc = perm_f(acc);
      end
      blocks.delete();

      mode_i = 3'(m);
      for (int i = 0; i < len; i++) begin
         if (i % 5 == 4) begin
            in_valid_i = 1'b0;
            @(negedge clk);
         end
         in_valid_i = 1'b1;
         in_byte_i  = msg[i];
         in_last_i  = (i == len - 1);
         while (!in_ready_o) @(negedge clk);
         @(negedge clk);
         if (i == 0) mode_i = 3'(m_alt);
      end
      in_valid_i = 1'b0;
      in_last_i  = 1'b0;
      in_byte_i  = 8'hEE;

      waitc = 0;
      while (!absorb_done_o && waitc < 4000) begin
         @(negedge clk);
         waitc++;
      end
      n_chk++;
      if (!absorb_done_o) begin
         n_fail++;
         $display("FAIL R9 (%s) absorb_done_o act=0 exp=1 mode %0d len %0d", tag, m, len);
      end
      n_chk++;
      if (blocks.size() != nblk) begin
         n_fail++;
         $display("FAIL R1 R5 (%s) block count act=%0d exp=%0d mode %0d len %0d",
                  tag, blocks.size(), nblk, m, len);
      end
      for (int k = 0; k < nblk && k < blocks.size(); k++) begin
         n_chk++;
         if (blocks[k] !== exp_q[k]) begin
            n_fail++;
            $display("FAIL %s block %0d mode %0d len %0d act=%h exp=%h",
                     tag, k, m, len, blocks[k], exp_q[k]);
         end
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: ready, idle outputs, zero state (R9)
      n_chk++;
      if (in_ready_o !== 1'b1 || perm_start_o !== 1'b0 || absorb_done_o !== 1'b0 || state_o !== '0) begin
         n_fail++;
         $display("FAIL R9 reset state act=%b%b%b exp=100 state_zero=%b",
                  in_ready_o, perm_start_o, absorb_done_o, (state_o == '0));
      end
      run_cmp = 1;

      run_msg(1,   3, 1, "R2 R3");   // short hash-mode message, 0x06 after byte 2
      run_msg(1, 135, 1, "R4");      // merged 0x86 in last rate byte
      run_msg(1, 136, 1, "R5");      // exact fill, padding-only block follows
      run_msg(4, 200, 3, "R10");     // mode changed mid-message must not matter
      run_msg(3, 150, 3, "R1");      // 72-byte rate, three blocks
      run_msg(0, 144, 0, "R5");      // exact fill at 144
      run_msg(2,   1, 2, "R1");      // 104-byte rate, one byte
      run_msg(6,  10, 6, "R3");      // 0x07 domain
      run_msg(7, 272, 7, "R6");      // two full blocks plus padding; capacity carried
      run_msg(5,  50, 5, "R3");      // 0x1F domain
      run_msg(4, 167, 4, "R4");      // merged 0x9F
      run_msg(1,   2, 1, "R9");      // back-to-back message starts from a cleared state

      repeat (4) @(negedge clk);
      ended = 1;
      summary();
      $finish;
   end

endmodule